// File: doc/BRIEF.md
# PTP Interrupt Status Aggregator

This block gathers the event pulses of a precision-time timestamping unit into one 32-bit interrupt status register and folds them into a single system interrupt. Event pulses come from two sources. Eight GPIO capture channels each report a rising edge and a falling edge. Three ports each report a transmit timestamp and a receive timestamp. Each pulse sets a sticky flag, and software clears a flag by writing 1 to it.

A second register holds one enable bit per flag. The flags that are both set and enabled are ORed into a cascaded event bit. That bit reaches the system interrupt output only when an upstream global event-enable input is also high. The output is a registered level.

Software reaches both registers over a plain bus made of a word address, write data, a write strobe and combinational read data. The capture logic and the per-port timestamp buffering sit outside the block; only their one-cycle event pulses enter it.

Top module: `ptp_irq_agg`

## Requirements
- R1: After reset the status register, the enable register and `irq_o` are all zero.
- R2: A one-cycle event pulse sets its status flag at the next clock edge. The flag positions are: falling-edge GPIO channel i at bit 24+i, rising-edge GPIO channel i at bit 16+i, transmit port p at bit 12+p, and receive port p at bit 8+p. The status register is read at word address 0.
- R3: A flag sets when its source fires even while the matching enable bit is clear.
- R4: A write to address 0 clears each status flag whose write-data bit is 1 and leaves the flags whose bit is 0 unchanged.
- R5: If an event and a write-1 clear hit the same flag in the same cycle, the flag is set after that edge.
- R6: Bits 15, 11 and 7:0 read as zero in both registers, and writes to those bits have no effect.
- R7: The enable register at word address 1 stores the written value on every implemented bit and reads it back.
- R8: `evt_o` is high exactly when some status flag and its enable bit are both 1, in the same cycle as the register contents.
- R9: `irq_o` equals `evt_o AND glb_evt_en_i` delayed by one clock. It therefore drops one cycle after the last enabled flag is cleared.
- R10: Reads of word addresses 2 and 3 return zero, and writes to them change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpio_rise_i | input | 8 | Rising-edge capture event pulses, one per GPIO channel |
| gpio_fall_i | input | 8 | Falling-edge capture event pulses, one per GPIO channel |
| tx_ts_i | input | 3 | Transmit timestamp event pulses, one per port |
| rx_ts_i | input | 3 | Receive timestamp event pulses, one per port |
| reg_addr_i | input | 2 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_we_i | input | 1 | Register write strobe |
| reg_rdata_o | output | 32 | Register read data, combinational from the address |
| glb_evt_en_i | input | 1 | Upstream global event enable |
| evt_o | output | 1 | Cascaded event bit: OR of status AND enable |
| irq_o | output | 1 | Registered system interrupt level |

## Verification
An event pulse and a write-1 clear of the same status flag can arrive in the same cycle. The bench drives both in one cycle, once on a clear flag and once on a flag that is already set, and then reads the register back. It expects the flag to be 1 both times. A lone clear that follows must then return the flag to 0, which shows that the earlier write really reached the register.

// File: rtl/ptp_irq_pkg.sv
package ptp_irq_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned ADDR_W  = 2;
  localparam int unsigned GPIO_N  = 8;
  localparam int unsigned PORT_N  = 3;
  localparam int unsigned RX_LSB  = 8;
  localparam int unsigned TX_LSB  = 12;
  localparam int unsigned RE_LSB  = 16;
  localparam int unsigned FE_LSB  = 24;

  typedef enum logic [ADDR_W-1:0] {
    A_STATUS = 2'd0,
    A_ENABLE = 2'd1,
    A_SPARE2 = 2'd2,
    A_SPARE3 = 2'd3
  } reg_addr_e;

  function automatic logic [REG_W-1:0] impl_mask(int unsigned ng, int unsigned np);
    logic [REG_W-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < ng; i++) begin
      m[RE_LSB+i] = 1'b1;
      m[FE_LSB+i] = 1'b1;
    end
    for (int unsigned p = 0; p < np; p++) begin
      m[RX_LSB+p] = 1'b1;
      m[TX_LSB+p] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/ptp_irq_src_map.sv
module ptp_irq_src_map
  import ptp_irq_pkg::*;
#(
  parameter int unsigned N_GPIO = GPIO_N,
  parameter int unsigned N_PORT = PORT_N
) (
  input  logic [N_GPIO-1:0] rise_i,
  input  logic [N_GPIO-1:0] fall_i,
  input  logic [N_PORT-1:0] tx_i,
  input  logic [N_PORT-1:0] rx_i,
  output logic [REG_W-1:0]  set_vec_o
);
  logic [N_GPIO-1:0] re_bits, fe_bits;
  logic [N_PORT-1:0] tx_bits, rx_bits;

  for (genvar g = 0; g < N_GPIO; g++) begin : g_gpio
    assign re_bits[g] = rise_i[g];
    assign fe_bits[g] = fall_i[g];
  end

  for (genvar p = 0; p < N_PORT; p++) begin : g_port
    assign tx_bits[p] = tx_i[p];
    assign rx_bits[p] = rx_i[p];
  end

  always_comb begin
    set_vec_o = '0;
    set_vec_o[RE_LSB +: N_GPIO] = re_bits;
    set_vec_o[FE_LSB +: N_GPIO] = fe_bits;
    set_vec_o[TX_LSB +: N_PORT] = tx_bits;
    set_vec_o[RX_LSB +: N_PORT] = rx_bits;
  end
endmodule

// File: rtl/ptp_irq_status_reg.sv
module ptp_irq_status_reg
  import ptp_irq_pkg::*;
#(
  parameter logic [REG_W-1:0] MASK = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] set_vec_i,
  input  logic [REG_W-1:0] clr_vec_i,
  output logic [REG_W-1:0] sts_o
);
  logic [REG_W-1:0] sts_q, sts_d;
  logic             sts_ce;

  always_comb begin
    sts_ce = (|(set_vec_i & MASK)) | (|(clr_vec_i & MASK));
    sts_d  = ((sts_q & ~clr_vec_i) | set_vec_i) & MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= '0;
    else if (sts_ce) sts_q <= sts_d;
  end

  assign sts_o = sts_q;

  // R2, R3, R5: every pulsed implemented flag is set after the edge
  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_vec_i & MASK) != '0) |=> ((sts_q & $past(set_vec_i & MASK)) == $past(set_vec_i & MASK)));

  // R4: a clear with no concurrent set empties the flag
  a_r4_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec_i & ~set_vec_i) != '0) |=> ((sts_q & $past(clr_vec_i & ~set_vec_i)) == '0));

  // R4: untouched flags keep their value
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sts_q & ~$past(set_vec_i | clr_vec_i)) == ($past(sts_q) & ~$past(set_vec_i | clr_vec_i))));

  // R6: reserved bits never hold a one
  a_r6_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q & ~MASK) == '0);
endmodule

// File: rtl/ptp_irq_enable_reg.sv
module ptp_irq_enable_reg
  import ptp_irq_pkg::*;
#(
  parameter logic [REG_W-1:0] MASK = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] en_o
);
  logic [REG_W-1:0] en_q, en_d;

  always_comb en_d = wdata_i & MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else if (we_i) en_q <= en_d;
  end

  assign en_o = en_q;

  // R7, R10: contents change only on a write strobe
  a_r10_en_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(en_q));
endmodule

// File: rtl/ptp_irq_combine.sv
module ptp_irq_combine
  import ptp_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] sts_i,
  input  logic [REG_W-1:0] en_i,
  input  logic             glb_en_i,
  output logic             evt_o,
  output logic             irq_o
);
  logic irq_d, irq_q;

  always_comb begin
    evt_o = |(sts_i & en_i);
    irq_d = evt_o & glb_en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  // R9: without the global enable the line is low next cycle
  a_r9_glb_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en_i |=> !irq_q);

  // R9: with no enabled flag the line is low next cycle
  a_r9_drop: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts_i & en_i) == '0) |=> !irq_q);
endmodule

// File: rtl/ptp_irq_agg.sv
module ptp_irq_agg
  import ptp_irq_pkg::*;
#(
  parameter int unsigned N_GPIO = GPIO_N,
  parameter int unsigned N_PORT = PORT_N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_GPIO-1:0] gpio_rise_i,
  input  logic [N_GPIO-1:0] gpio_fall_i,
  input  logic [N_PORT-1:0] tx_ts_i,
  input  logic [N_PORT-1:0] rx_ts_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  input  logic              reg_we_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              glb_evt_en_i,
  output logic              evt_o,
  output logic              irq_o
);
  localparam logic [REG_W-1:0] IMPL = impl_mask(N_GPIO, N_PORT);

  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  logic [REG_W-1:0] set_vec, clr_vec, sts, en;
  logic             wr_sts, wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  always_comb begin
    wr_sts  = reg_we_i && (reg_addr_i == A_STATUS);
    wr_en   = reg_we_i && (reg_addr_i == A_ENABLE);
    clr_vec = wr_sts ? (reg_wdata_i & IMPL) : '0;
  end

  ptp_irq_src_map #(.N_GPIO(N_GPIO), .N_PORT(N_PORT)) u_map (
    .rise_i(gpio_rise_i), .fall_i(gpio_fall_i),
    .tx_i(tx_ts_i), .rx_i(rx_ts_i), .set_vec_o(set_vec)
  );

  ptp_irq_status_reg #(.MASK(IMPL)) u_sts (
    .clk(clk), .rst_n(rst_sync_n), .set_vec_i(set_vec),
    .clr_vec_i(clr_vec), .sts_o(sts)
  );

  ptp_irq_enable_reg #(.MASK(IMPL)) u_en (
    .clk(clk), .rst_n(rst_sync_n), .we_i(wr_en),
    .wdata_i(reg_wdata_i), .en_o(en)
  );

  ptp_irq_combine u_comb (
    .clk(clk), .rst_n(rst_sync_n), .sts_i(sts), .en_i(en),
    .glb_en_i(glb_evt_en_i), .evt_o(evt_o), .irq_o(irq_o)
  );

  always_comb begin
    unique case (reg_addr_i)
      A_STATUS: reg_rdata_o = sts;
      A_ENABLE: reg_rdata_o = en;
      default:  reg_rdata_o = '0;
    endcase
  end

  // R6: read data never shows reserved bits
  a_r6_rd_rsvd: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_rdata_o & ~IMPL) == '0);

  // R10: spare addresses read zero
  a_r10_spare_rd: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_addr_i[1]) |-> (reg_rdata_o == '0));
endmodule

// File: tb/ptp_irq_agg_tb.sv
module ptp_irq_agg_tb;
  logic        clk, rst_n;
  logic [7:0]  rise, fall;
  logic [2:0]  tx, rx;
  logic [1:0]  addr;
  logic [31:0] wdata, rdata;
  logic        we, glb, evt, irq;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  ptp_irq_agg u_dut (
    .clk(clk), .rst_n(rst_n), .gpio_rise_i(rise), .gpio_fall_i(fall),
    .tx_ts_i(tx), .rx_ts_i(rx), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_we_i(we), .reg_rdata_o(rdata), .glb_evt_en_i(glb),
    .evt_o(evt), .irq_o(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // vector: rise, fall, tx, rx, expected status
  localparam int NV = 6;
  localparam logic [53:0] VEC [NV] = '{
    {8'h01, 8'h00, 3'b000, 3'b000, 32'h0001_0000},
    {8'h00, 8'h80, 3'b000, 3'b000, 32'h8000_0000},
    {8'h00, 8'h00, 3'b101, 3'b000, 32'h0000_5000},
    {8'h00, 8'h00, 3'b000, 3'b010, 32'h0000_0200},
    {8'hFF, 8'hFF, 3'b111, 3'b111, 32'hFFFF_7700},
    {8'hA5, 8'h3C, 3'b010, 3'b100, 32'h3CA5_2400}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic pulse(input logic [7:0] r, input logic [7:0] f,
                       input logic [2:0] t, input logic [2:0] x);
    @(negedge clk);
    rise = r; fall = f; tx = t; rx = x;
    @(negedge clk);
    rise = '0; fall = '0; tx = '0; rx = '0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; rise = '0; fall = '0; tx = '0; rx = '0;
    addr = '0; wdata = '0; we = 1'b0; glb = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(2'd0, d); chk("R1 status", d, 32'h0);
    rd(2'd1, d); chk("R1 enable", d, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // R2 / R3 vector table, enables all clear
    for (int i = 0; i < NV; i++) begin
      pulse(VEC[i][53:46], VEC[i][45:38], VEC[i][37:35], VEC[i][34:32]);
      rd(2'd0, d); chk("R2/R3 vector status", d, VEC[i][31:0]);
      chk("R3 evt low with enables clear", {31'b0, evt}, 32'h0);
      wr(2'd0, 32'hFFFF_FFFF);
      rd(2'd0, d); chk("R4 clear all", d, 32'h0);
    end

    // R7 / R6 enable read-back, reserved bits zero
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, d); chk("R7/R6 enable readback", d, 32'hFFFF_7700);
    wr(2'd1, 32'h0000_88FF);
    rd(2'd1, d); chk("R6 enable reserved write", d, 32'h0);
    wr(2'd0, 32'h0000_88FF);
    rd(2'd0, d); chk("R6 status reserved write", d, 32'h0);

    // R8 / R9 cascade and global gate
    wr(2'd1, 32'h0001_0000);
    pulse(8'h02, 8'h00, 3'b000, 3'b000);
    #1 chk("R8 evt from unenabled flag", {31'b0, evt}, 32'h0);
    wr(2'd0, 32'h0002_0000);
    pulse(8'h01, 8'h00, 3'b000, 3'b000);
    #1 chk("R8 evt high", {31'b0, evt}, 32'h1);
    @(negedge clk);
    chk("R9 irq gated by global enable", {31'b0, irq}, 32'h0);
    glb = 1'b1;
    @(negedge clk);
    chk("R9 irq one cycle after global enable", {31'b0, irq}, 32'h1);

    // R4 write of zero keeps flag
    wr(2'd0, 32'h0000_0000);
    rd(2'd0, d); chk("R4 write zero keeps", d, 32'h0001_0000);
    // R4 / R9 clear, irq drops one cycle later
    wr(2'd0, 32'h0001_0000);
    #1 chk("R8 evt low after clear", {31'b0, evt}, 32'h0);
    chk("R9 irq still high at clear edge", {31'b0, irq}, 32'h1);
    @(negedge clk);
    chk("R9 irq low one cycle later", {31'b0, irq}, 32'h0);

    // R5 event and clear in same cycle
    @(negedge clk);
    rise = 8'h02; addr = 2'd0; wdata = 32'h0002_0000; we = 1'b1;
    @(negedge clk);
    rise = '0; we = 1'b0; wdata = '0;
    rd(2'd0, d); chk("R5 set wins on clear flag", d, 32'h0002_0000);
    @(negedge clk);
    tx = 3'b001; rise = 8'h02; addr = 2'd0; wdata = 32'h0002_1000; we = 1'b1;
    @(negedge clk);
    tx = '0; rise = '0; we = 1'b0; wdata = '0;
    rd(2'd0, d); chk("R5 set wins on set flag", d, 32'h0002_1000);
    wr(2'd0, 32'h0002_1000);
    rd(2'd0, d); chk("R4 lone clear after collision", d, 32'h0);

    // R10 spare addresses
    wr(2'd2, 32'hFFFF_FFFF);
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd1, d); chk("R10 enable unchanged", d, 32'h0001_0000);
    pulse(8'h00, 8'h01, 3'b000, 3'b000);
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd0, d); chk("R10 status unchanged", d, 32'h0100_0000);
    rd(2'd2, d); chk("R10 read addr 2", d, 32'h0);
    rd(2'd3, d); chk("R10 read addr 3", d, 32'h0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule